// File: doc/BRIEF.md
# Set-Associative Tag Directory with Selectable Replacement

This block is the tag-only lookup stage of a set-associative cache. Each accepted request carries a byte address. The block cuts the address into three fields: a tag in the upper bits, a set index in the middle bits and a line offset in the lower bits. It then compares the tag against every way of the selected set at the same time. One cycle later it returns hit or miss, the way that was used, and on a miss whether a valid line was displaced and which tag that line held.

On a miss the block allocates a way straight away. If the set has a free way, that way is used. Otherwise the replacement policy picks the victim. A static input chooses the policy. With first-in-first-out, the line filled earliest is replaced. With least-recently-used, the line touched longest ago is replaced. A running miss counter lets the two policies be compared on the same address trace. The data array, write-back and coherence belong to the surrounding cache.

Top module: `assoc_tag_directory`

## Requirements
- R1: The address is split, from most to least significant bit, into a tag of ADDR_W-SET_W-OFFS_W bits, a set index of SET_W bits and an offset of OFFS_W bits. The offset bits have no effect on hit, way or allocation.
- R2: A hit is reported only when the request tag equals the stored tag of a valid way in the indexed set. Lines held in other sets never produce a hit.
- R3: `req_ready` is high whenever reset is not asserted. `resp_valid` is high in exactly the cycle after a request is accepted and low otherwise.
- R4: On a miss in a set that still has an invalid way, the lowest-numbered invalid way is filled, and `resp_evict` is 0.
- R5: When `policy_lru` is 0 (FIFO) and the set is full, the way filled earliest is replaced. Hits do not change this order.
- R6: When `policy_lru` is 1 (LRU) and the set is full, the way whose last hit or fill is oldest is replaced. A hit makes that way the most recent.
- R7: `miss_count` increases by exactly one for each miss response and keeps its value in every other cycle.
- R8: Reset clears all valid bits, the replacement order and `miss_count`, and holds `resp_valid` low.
- R9: When a miss replaces a valid line, `resp_evict` is 1 and `resp_evict_tag` holds that line's tag. `resp_way` is the hit way on a hit and the filled way on a miss.
- R10: With WAYS = 1 (direct-mapped), every access uses way 0, and a miss on an occupied line always replaces it.
- R11: With 2 ways and every access mapping to one set, the trace A B C A B C B A B D (four distinct tags) gives 9 misses under FIFO and 8 under LRU.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| policy_lru | input | 1 | Replacement choice: 0 selects FIFO, 1 selects LRU |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Byte address of the request |
| resp_valid | output | 1 | Response present (one cycle after acceptance) |
| resp_hit | output | 1 | 1 on a hit, 0 on a miss |
| resp_way | output | WAY_W | Way that hit or was filled |
| resp_evict | output | 1 | A valid line was replaced by this miss |
| resp_evict_tag | output | TAG_W | Tag of the replaced line |
| miss_count | output | CNT_W | Misses since reset, wrapping |

## Verification
Several properties are checked on every cycle of every run. These are the one-cycle request-to-response timing, the rule that a tag matches at most one way of a set, the step-by-one behaviour of the miss counter, the rule that an eviction never goes with a hit, and the rule that a miss in a set with a free way never evicts. Which victim each policy picks, and whether a hit reorders the ways, depend on the history of the set. Only the bench's scenarios can show these. The two-way trace with its expected per-access way and total miss count under both policies covers them, as do the directed cases for offset independence, set isolation, reset clearing and the direct-mapped variant.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;
   // index width that never collapses to zero bits
   function automatic int idx_bits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/tagdir_addr_split.sv
module tagdir_addr_split #(
   parameter int ADDR_W = 32,
   parameter int SET_W  = 7,
   parameter int OFFS_W = 5,
   parameter int TAG_W  = ADDR_W - SET_W - OFFS_W
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [TAG_W-1:0]  tag,
   output logic [SET_W-1:0]  set_idx
);
   logic unused_offset;

   // tag on top, set index in the middle, offset at the bottom (R1)
   assign tag           = addr[ADDR_W-1 -: TAG_W];
   assign set_idx       = addr[OFFS_W +: SET_W];
   assign unused_offset = ^addr[OFFS_W-1:0];
endmodule

// File: rtl/tagdir_way_match.sv
module tagdir_way_match #(
   parameter int WAYS  = 4,
   parameter int TAG_W = 20,
   parameter int WAY_W = 2
) (
   input  logic [WAYS-1:0]            row_valid,
   input  logic [WAYS-1:0][TAG_W-1:0] row_tag,
   input  logic [TAG_W-1:0]           tag,
   output logic [WAYS-1:0]            hit_vec,
   output logic                       hit,
   output logic [WAY_W-1:0]           hit_way
);
   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign hit_vec[w] = row_valid[w] && (row_tag[w] == tag);
   end

   assign hit = |hit_vec;

   always_comb begin
      hit_way = '0;
      for (int w = 0; w < WAYS; w++)
         if (hit_vec[w]) hit_way = WAY_W'(w);
   end
endmodule

// File: rtl/tagdir_victim_pick.sv
module tagdir_victim_pick #(
   parameter int WAYS   = 4,
   parameter int WAY_W  = 2,
   parameter int RANK_W = 2
) (
   input  logic [WAYS-1:0]             row_valid,
   input  logic [WAYS-1:0][RANK_W-1:0] row_rank,
   output logic [WAY_W-1:0]            vict_way,
   output logic                        set_full
);
   if (WAYS == 1) begin : g_direct
      logic unused_rank;
      assign unused_rank = ^row_rank;
      assign vict_way    = '0;
      assign set_full    = row_valid[0];
   end else begin : g_assoc
      logic found;
      assign set_full = &row_valid;
      always_comb begin
         vict_way = '0;
         found    = 1'b0;
         // free way first, lowest index wins (R4)
         for (int w = 0; w < WAYS; w++) begin
            if (!row_valid[w] && !found) begin
               vict_way = WAY_W'(w);
               found    = 1'b1;
            end
         end
         // otherwise the oldest rank (R5/R6)
         if (!found) begin
            for (int w = 0; w < WAYS; w++)
               if (row_rank[w] == RANK_W'(WAYS - 1)) vict_way = WAY_W'(w);
         end
      end
   end
endmodule

// File: rtl/assoc_tag_directory.sv
module assoc_tag_directory
   import tagdir_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int SET_W  = 7,
   parameter int OFFS_W = 5,
   parameter int WAYS   = 4,
   parameter int CNT_W  = 16,
   localparam int TAG_W  = ADDR_W - SET_W - OFFS_W,
   localparam int WAY_W  = idx_bits(WAYS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              policy_lru,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              resp_valid,
   output logic              resp_hit,
   output logic [WAY_W-1:0]  resp_way,
   output logic              resp_evict,
   output logic [TAG_W-1:0]  resp_evict_tag,
   output logic [CNT_W-1:0]  miss_count
);
   localparam int SETS   = 1 << SET_W;
   localparam int RANK_W = WAY_W;

   if (TAG_W < 1) begin : g_bad_tag
      $error("tag field must be at least one bit");
   end
   if (OFFS_W < 1 || SET_W < 1) begin : g_bad_split
      $error("set and offset fields must be at least one bit");
   end
   if (WAYS < 1) begin : g_bad_ways
      $error("at least one way required");
   end

   // state: valid, tag and age rank per way (rank 0 = newest)
   logic [WAYS-1:0]                         valid_q [SETS];
   logic [WAYS-1:0][TAG_W-1:0]              tag_q   [SETS];
   logic [WAYS-1:0][RANK_W-1:0]             rank_q  [SETS];

   logic [TAG_W-1:0]            req_tag;
   logic [SET_W-1:0]            set_idx;
   logic [WAYS-1:0]             row_valid;
   logic [WAYS-1:0][TAG_W-1:0]  row_tag;
   logic [WAYS-1:0][RANK_W-1:0] row_rank;
   logic [WAYS-1:0][RANK_W-1:0] next_rank;
   logic [WAYS-1:0]             hit_vec;
   logic                        hit;
   logic [WAY_W-1:0]            hit_way;
   logic [WAY_W-1:0]            vict_way;
   logic                        set_full;
   logic [WAY_W-1:0]            use_way;
   logic [RANK_W-1:0]           old_rank;
   logic                        accept;

   tagdir_addr_split #(
      .ADDR_W(ADDR_W), .SET_W(SET_W), .OFFS_W(OFFS_W), .TAG_W(TAG_W)
   ) u_split (
      .addr(req_addr), .tag(req_tag), .set_idx(set_idx)
   );

   assign row_valid = valid_q[set_idx];
   assign row_tag   = tag_q[set_idx];
   assign row_rank  = rank_q[set_idx];

   tagdir_way_match #(
      .WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)
   ) u_match (
      .row_valid(row_valid), .row_tag(row_tag), .tag(req_tag),
      .hit_vec(hit_vec), .hit(hit), .hit_way(hit_way)
   );

   tagdir_victim_pick #(
      .WAYS(WAYS), .WAY_W(WAY_W), .RANK_W(RANK_W)
   ) u_victim (
      .row_valid(row_valid), .row_rank(row_rank),
      .vict_way(vict_way), .set_full(set_full)
   );

   assign req_ready = rst_n;
   assign accept    = req_valid && req_ready;
   assign use_way   = hit ? hit_way : vict_way;
   assign old_rank  = row_rank[use_way];

   // move the used way to rank 0, age every way that was newer
   always_comb begin
      next_rank = row_rank;
      for (int w = 0; w < WAYS; w++) begin
         if (WAY_W'(w) == use_way)
            next_rank[w] = '0;
         else if (row_rank[w] < old_rank)
            next_rank[w] = row_rank[w] + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            valid_q[s] <= '0;
            for (int w = 0; w < WAYS; w++)
               rank_q[s][w] <= RANK_W'(w);
         end
      end else if (accept) begin
         if (!hit) valid_q[set_idx][use_way] <= 1'b1;
         // FIFO keeps order on hits, LRU promotes (R5/R6)
         if (!hit || policy_lru) rank_q[set_idx] <= next_rank;
      end
   end

   always_ff @(posedge clk) begin
      if (accept && !hit) tag_q[set_idx][use_way] <= req_tag;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resp_valid     <= 1'b0;
         resp_hit       <= 1'b0;
         resp_way       <= '0;
         resp_evict     <= 1'b0;
         resp_evict_tag <= '0;
         miss_count     <= '0;
      end else begin
         resp_valid <= accept;
         if (accept) begin
            resp_hit       <= hit;
            resp_way       <= use_way;
            resp_evict     <= !hit && set_full;
            resp_evict_tag <= row_tag[vict_way];
            if (!hit) miss_count <= miss_count + 1'b1;
         end
      end
   end

   assert_resp_follows_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid == $past(req_valid && req_ready));

   assert_one_hit_way_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

   assert_miss_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && !resp_hit) |-> (miss_count == $past(miss_count) + 1'b1));

   assert_miss_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(resp_valid && !resp_hit) |-> $stable(miss_count));

   assert_evict_only_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && resp_evict) |-> !resp_hit);

   assert_free_way_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !hit && !set_full) |=> (resp_valid && !resp_evict));
endmodule

// File: tb/assoc_tag_directory_test.sv
`timescale 1ns/1ps
module assoc_tag_directory_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic policy_lru = 1'b0;
   logic req_valid = 1'b0;
   logic req_ready;
   logic [7:0] req_addr = '0;
   logic resp_valid, resp_hit, resp_way, resp_evict;
   logic [3:0] resp_evict_tag;
   logic [15:0] miss_count;

   logic dm_valid = 1'b0;
   logic dm_ready;
   logic [7:0] dm_addr = '0;
   logic dm_rvalid, dm_hit, dm_way, dm_evict;
   logic [3:0] dm_evict_tag;
   logic [15:0] dm_misses;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   assoc_tag_directory #(.ADDR_W(8), .SET_W(2), .OFFS_W(2), .WAYS(2), .CNT_W(16)) uut (
      .clk(clk), .rst_n(rst_n), .policy_lru(policy_lru),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_way(resp_way),
      .resp_evict(resp_evict), .resp_evict_tag(resp_evict_tag), .miss_count(miss_count));

   assoc_tag_directory #(.ADDR_W(8), .SET_W(2), .OFFS_W(2), .WAYS(1), .CNT_W(16)) uut_dm (
      .clk(clk), .rst_n(rst_n), .policy_lru(1'b0),
      .req_valid(dm_valid), .req_ready(dm_ready), .req_addr(dm_addr),
      .resp_valid(dm_rvalid), .resp_hit(dm_hit), .resp_way(dm_way),
      .resp_evict(dm_evict), .resp_evict_tag(dm_evict_tag), .miss_count(dm_misses));

   // {lru, addr, expected hit, expected way}; A=0x10 B=0x20 C=0x30 D=0x40, all set 0
   localparam logic [10:0] TRACE [20] = '{
      {1'b0, 8'h10, 1'b0, 1'b0}, {1'b0, 8'h20, 1'b0, 1'b1}, {1'b0, 8'h30, 1'b0, 1'b0},
      {1'b0, 8'h10, 1'b0, 1'b1}, {1'b0, 8'h20, 1'b0, 1'b0}, {1'b0, 8'h30, 1'b0, 1'b1},
      {1'b0, 8'h20, 1'b1, 1'b0}, {1'b0, 8'h10, 1'b0, 1'b0}, {1'b0, 8'h20, 1'b0, 1'b1},
      {1'b0, 8'h40, 1'b0, 1'b0},
      {1'b1, 8'h10, 1'b0, 1'b0}, {1'b1, 8'h20, 1'b0, 1'b1}, {1'b1, 8'h30, 1'b0, 1'b0},
      {1'b1, 8'h10, 1'b0, 1'b1}, {1'b1, 8'h20, 1'b0, 1'b0}, {1'b1, 8'h30, 1'b0, 1'b1},
      {1'b1, 8'h20, 1'b1, 1'b0}, {1'b1, 8'h10, 1'b0, 1'b1}, {1'b1, 8'h20, 1'b1, 1'b0},
      {1'b1, 8'h40, 1'b0, 1'b1}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // drive one request for a cycle; outputs are sampled at the following negedge
   task automatic access(input logic [7:0] a);
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = a;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic dm_access(input logic [7:0] a);
      @(negedge clk);
      dm_valid = 1'b1;
      dm_addr  = a;
      @(negedge clk);
      dm_valid = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R3 watchdog actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 20; i++) begin
         if (i == 0 || i == 10) begin
            policy_lru = TRACE[i][10];
            do_reset();
         end
         access(TRACE[i][9:2]);
         check(TRACE[i][10] ? "R6 trace response" : "R5 trace response", resp_valid, 1'b1);
         check(TRACE[i][10] ? "R6 trace hit" : "R5 trace hit", resp_hit, TRACE[i][1]);
         check(TRACE[i][10] ? "R6 trace way" : "R5 trace way", resp_way, TRACE[i][0]);
         if (i == 9)  check("R11 FIFO miss total", miss_count, 9);
         if (i == 19) check("R11 LRU miss total", miss_count, 8);
      end

      // reset state
      policy_lru = 1'b0;
      do_reset();
      check("R8 resp_valid after reset", resp_valid, 1'b0);
      check("R8 miss_count after reset", miss_count, 0);
      check("R3 ready out of reset", req_ready, 1'b1);

      access(8'h40);
      check("R8 line cleared by reset", resp_hit, 1'b0);
      check("R4 first free way", resp_way, 1'b0);
      check("R4 no eviction into free way", resp_evict, 1'b0);

      access(8'h43);
      check("R1 offset ignored hit", resp_hit, 1'b1);
      check("R1 offset ignored way", resp_way, 1'b0);

      access(8'h44);
      check("R2 other set misses", resp_hit, 1'b0);
      check("R2 other set way", resp_way, 1'b0);

      access(8'h50);
      check("R4 second free way", resp_way, 1'b1);
      check("R4 second fill no evict", resp_evict, 1'b0);

      access(8'h60);
      check("R9 evict flag", resp_evict, 1'b1);
      check("R9 evict tag", resp_evict_tag, 4'h4);
      check("R9 filled way", resp_way, 1'b0);
      check("R7 miss_count after four misses", miss_count, 4);

      @(negedge clk);
      check("R3 no response when idle", resp_valid, 1'b0);
      check("R7 count holds when idle", miss_count, 4);

      // FIFO: hit on way1 (tag 5) must not protect it
      access(8'h50);
      check("R5 hit in FIFO", resp_hit, 1'b1);
      check("R7 hit leaves count", miss_count, 4);
      access(8'h70);
      check("R5 FIFO ignores hit: way", resp_way, 1'b1);
      check("R5 FIFO ignores hit: tag", resp_evict_tag, 4'h5);

      // direct-mapped variant
      dm_access(8'h10);
      check("R10 dm first miss", dm_hit, 1'b0);
      check("R10 dm way", dm_way, 1'b0);
      dm_access(8'h11);
      check("R10 dm hit", dm_hit, 1'b1);
      dm_access(8'h20);
      check("R10 dm conflict miss", dm_hit, 1'b0);
      check("R10 dm evict flag", dm_evict, 1'b1);
      check("R10 dm evict tag", dm_evict_tag, 4'h1);
      check("R10 dm miss total", dm_misses, 2);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule